// File: doc/BRIEF.md
# I2C Control Register Bank

This block is an I2C target that lets a host controller read and write a bank of eight 8-bit control registers inside a converter chip. It runs on the chip's system clock. It oversamples the bus clock and data lines, finds START and STOP conditions, and answers one 7-bit bus address. That address is a fixed six-bit prefix followed by a bit taken from a board strap input. Data goes out on an open-drain pull-down output.

A write transfer carries a pointer byte after the address. Bit 7 of the pointer enables auto-increment, and bits 2:0 select a register. Each later byte in the transfer is stored in the selected register. A read transfer returns the register the pointer currently selects. To read from a chosen register, the host writes the pointer and then issues a repeated START with a read address. The pointer keeps its value across the repeated START.

Two kinds of content come from hardware and cannot be written over the bus. All of register 6 is status. In register 1, bit 0 is a clock-fault flag and bit 1 is a calibration-busy flag. The block presents every register as a parallel bus. It also raises a flag when the three-bit emphasis-select field in register 2 (bits 2:0) is zero, which means external pins are in control.

Top module: `i2c_regbank_port`

## Requirements
- R1: The block acknowledges an address byte, by pulling SDA low during the ninth clock, only when the byte's upper seven bits equal 0b001000 followed by the `strap_i` level. The byte's bit 0 selects the direction: 1 is a read and 0 is a write.
- R2: When the address does not match, the block leaves SDA released through the acknowledge bit and all later bits. It stores nothing until the next START.
- R3: In a write transfer, the first byte after the address loads the pointer. Every following byte is stored in the register selected by pointer bits 2:0. Each of these bytes is acknowledged.
- R4: A read transfer returns the register selected by the pointer. Data is sent MSB first.
- R5: When pointer bit 7 is 1, the register index advances by one after each data byte written or read, and index 7 wraps to 0. When pointer bit 7 is 0, the index stays the same.
- R6: Register 6 always shows `status_i`. Register 1 bit 0 shows `clk_fault_i` and bit 1 shows `cal_busy_i`. Bus writes to these bits have no effect, and the other bits of register 1 stay writable.
- R7: After reset, every writable bit is 0, so `deemph_pin_ctrl_o` is 1. This output is 1 exactly when register 2 bits 2:0 are zero.
- R8: When the host does not acknowledge a read byte, the read ends. SDA stays released until the next START or STOP.
- R9: A repeated START aborts the current transfer and starts address matching again. The pointer keeps its value.
- R10: `regs_o` carries register i on bits 8i+7 to 8i, showing the same value that a bus read would return.
- R11: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 1 | Strap level for address bit 0 |
| clk_fault_i | input | 1 | Hardware clock-fault flag (register 1 bit 0) |
| cal_busy_i | input | 1 | Hardware calibration-busy flag (register 1 bit 1) |
| status_i | input | 8 | Hardware status byte (register 6) |
| deemph_pin_ctrl_o | output | 1 | Emphasis select field is zero |
| regs_o | output | 64 | All registers, register i on bits 8i+7 to 8i |

## Verification
The hardest case to reach from the ports is a read that starts from a chosen register. It needs a pointer-only write, then a repeated START raised while the block has just released its acknowledge, and it depends on the pointer surviving that abort. The bench's host tasks build this sequence bit by bit: write address, pointer byte, SDA raised while SCL is low, START, read address. It then reads a burst that crosses registers holding both hardware-owned and host-written bits, and ends that burst with a NACK so that the release can be observed.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 3;
    localparam int NREGS      = 1 << IDX_W;
    localparam int AUTO_BIT   = 7;
    localparam int STATUS_IDX = 6;
    localparam int CTRL_IDX   = 1;
    localparam logic [DATA_W-1:0] CTRL_RO = 8'h03;
    localparam int DEEMPH_IDX = 2;
    localparam int DEEMPH_W   = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
        ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_IGN
    } fsm_e;

    typedef struct packed {
        fsm_e              st;
        logic [3:0]        cnt;
        logic [DATA_W-1:0] sh;
        logic              rw;
        logic              armed;
        logic [DATA_W-1:0] map;
        logic              pull;
    } ctl_t;

    function automatic logic [DATA_W-1:0] wmask(input int i);
        if (i == STATUS_IDX)    return '0;
        else if (i == CTRL_IDX) return ~CTRL_RO;
        else                    return '1;
    endfunction
endpackage

// File: rtl/i2c_rb_linemon.sv
module i2c_rb_linemon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q;
    logic scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;

    always_comb begin
        scl_d      = {scl_q[STAGES-2:0], scl_i};
        sda_d      = {sda_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_q[STAGES-1];
        sda_prev_d = sda_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o    = scl_q[STAGES-1];
    assign sda_o    = sda_q[STAGES-1];
    assign scl_rise = scl_o & ~scl_prev_q;
    assign scl_fall = ~scl_o & scl_prev_q;
    assign start    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank
    import i2c_rb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        widx,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [IDX_W-1:0]        ridx,
    input  logic                    clk_fault,
    input  logic                    cal_busy,
    input  logic [DATA_W-1:0]       status,
    output logic [DATA_W-1:0]       rdata,
    output logic [NREGS*DATA_W-1:0] view
);
    logic [DATA_W-1:0] reg_d [NREGS];
    logic [DATA_W-1:0] reg_q [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] WM = wmask(i);
        logic [DATA_W-1:0] hw;

        if (i == STATUS_IDX) begin : g_stat
            assign hw = status;
        end else if (i == CTRL_IDX) begin : g_ctrl
            assign hw = {{(DATA_W-2){1'b0}}, cal_busy, clk_fault};
        end else begin : g_plain
            assign hw = '0;
        end

        always_comb begin
            reg_d[i] = reg_q[i];
            if (we && widx == IDX_W'(i)) reg_d[i] = wdata & WM;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q[i] <= '0;
            else        reg_q[i] <= reg_d[i];
        end

        assign view[i*DATA_W +: DATA_W] = (reg_q[i] & WM) | (hw & ~WM);

        // R3
        wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == IDX_W'(i)) |=> (reg_q[i] == ($past(wdata) & WM)));
        // R2
        wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == IDX_W'(i)) |=> $stable(reg_q[i]));
    end

    assign rdata = view[DATA_W*int'(ridx) +: DATA_W];
endmodule

// File: rtl/i2c_regbank_port.sv
module i2c_regbank_port
    import i2c_rb_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    input  logic                    strap_i,
    input  logic                    clk_fault_i,
    input  logic                    cal_busy_i,
    input  logic [DATA_W-1:0]       status_i,
    output logic                    deemph_pin_ctrl_o,
    output logic [NREGS*DATA_W-1:0] regs_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    ctl_t c_d, c_q;
    logic wr_en;
    logic [DATA_W-1:0] in_byte, rd_byte;

    i2c_rb_linemon #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start(start), .stop(stop)
    );

    i2c_rb_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(c_q.map[IDX_W-1:0]),
        .wdata(in_byte), .ridx(c_q.map[IDX_W-1:0]), .clk_fault(clk_fault_i),
        .cal_busy(cal_busy_i), .status(status_i), .rdata(rd_byte), .view(regs_o)
    );

    assign in_byte = {c_q.sh[DATA_W-2:0], sda_s};

    always_comb begin
        c_d   = c_q;
        wr_en = 1'b0;
        if (start) begin
            c_d.st    = ST_ADDR;
            c_d.cnt   = '0;
            c_d.pull  = 1'b0;
            c_d.armed = 1'b0;
        end else if (stop) begin
            c_d.st   = ST_IDLE;
            c_d.pull = 1'b0;
        end else begin
            case (c_q.st)
                ST_ADDR, ST_PTR, ST_WDAT: begin
                    if (scl_rise) begin
                        c_d.sh  = in_byte;
                        c_d.cnt = c_q.cnt + 4'd1;
                        if (c_q.cnt == 4'd7) begin
                            c_d.cnt   = '0;
                            c_d.armed = 1'b0;
                            if (c_q.st == ST_ADDR) begin
                                if (in_byte[7:1] == {ADDR_PREFIX, strap_i}) begin
                                    c_d.rw = in_byte[0];
                                    c_d.st = ST_AACK;
                                end else begin
                                    c_d.st = ST_IGN;
                                end
                            end else if (c_q.st == ST_PTR) begin
                                c_d.map = in_byte;
                                c_d.st  = ST_PACK;
                            end else begin
                                wr_en = 1'b1;
                                if (c_q.map[AUTO_BIT])
                                    c_d.map[IDX_W-1:0] = c_q.map[IDX_W-1:0] + 1'b1;
                                c_d.st = ST_WACK;
                            end
                        end
                    end
                end
                ST_AACK, ST_PACK, ST_WACK: begin
                    if (scl_fall) begin
                        if (!c_q.armed) begin
                            c_d.pull  = 1'b1;
                            c_d.armed = 1'b1;
                        end else begin
                            c_d.armed = 1'b0;
                            c_d.cnt   = '0;
                            c_d.pull  = 1'b0;
                            if (c_q.st == ST_AACK && c_q.rw) begin
                                c_d.st   = ST_RDAT;
                                c_d.sh   = rd_byte;
                                c_d.pull = ~rd_byte[DATA_W-1];
                            end else if (c_q.st == ST_AACK) begin
                                c_d.st = ST_PTR;
                            end else begin
                                c_d.st = ST_WDAT;
                            end
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (c_q.cnt == 4'd8) begin
                            c_d.pull  = 1'b0;
                            c_d.armed = 1'b0;
                            c_d.st    = ST_RACK;
                            if (c_q.map[AUTO_BIT])
                                c_d.map[IDX_W-1:0] = c_q.map[IDX_W-1:0] + 1'b1;
                        end else begin
                            c_d.sh   = {c_q.sh[DATA_W-2:0], 1'b0};
                            c_d.pull = ~c_q.sh[DATA_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) c_d.st = ST_IGN;
                        else       c_d.armed = 1'b1;
                    end else if (scl_fall && c_q.armed) begin
                        c_d.st    = ST_RDAT;
                        c_d.cnt   = '0;
                        c_d.armed = 1'b0;
                        c_d.sh    = rd_byte;
                        c_d.pull  = ~rd_byte[DATA_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sda_pull_o        = c_q.pull;
    assign deemph_pin_ctrl_o = (regs_o[DEEMPH_IDX*DATA_W +: DEEMPH_W] == '0);

    // R2
    quiet_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE || c_q.st == ST_IGN) |-> !sda_pull_o);
    // R1
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_AACK && c_q.armed) |-> sda_pull_o);
    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && c_q.map[AUTO_BIT]) |=>
        (c_q.map[IDX_W-1:0] == $past(c_q.map[IDX_W-1:0]) + 1'b1));
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_q.st == ST_ADDR && !sda_pull_o && $stable(c_q.map)));
    // R11
    scl_low_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && !$past(start) && !$past(stop)) |-> !$past(scl_s));
endmodule

// File: tb/i2c_regbank_port_test.sv
module i2c_regbank_port_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, scl_m, sda_m, strap, clk_fault, cal_busy;
    logic [7:0] stat;
    logic sda_pull, deemph;
    logic [63:0] regs;
    wire sda_line = sda_m & ~sda_pull;

    int checks = 0, errors = 0, r11_bad = 0;
    bit done = 0;
    logic [7:0] m [8];
    logic pull_prev = 1'b0;

    i2c_regbank_port uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_i(strap), .clk_fault_i(clk_fault),
        .cal_busy_i(cal_busy), .status_i(stat), .deemph_pin_ctrl_o(deemph),
        .regs_o(regs)
    );

    always @(negedge clk) begin
        if (rst_n && sda_pull !== pull_prev && scl_m) r11_bad++;
        pull_prev <= sda_pull;
    end

    function automatic logic [7:0] view(input int i);
        if (i == 6) return stat;
        if (i == 1) return (m[1] & 8'hFC) | {6'b0, cal_busy, clk_fault};
        return m[i];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq();
    endtask
    task automatic bus_stop();
        sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq();
    endtask
    task automatic put_bit(input logic v);
        sda_m = v; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq();
    endtask
    task automatic get_bit(output logic v);
        sda_m = 1; hq(); scl_m = 1; hq(); v = sda_line; hq(); scl_m = 0; hq();
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v);
        ack = ~v;
    endtask
    task automatic recv_byte(input logic host_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) get_bit(b[i]);
        put_bit(~host_ack);
        sda_m = 1;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) chk(req, regs[i*8 +: 8], view(i));
    endtask

    task automatic t_reset();
        check_all("R7/R10 reset");
        chk("R7 pin ctrl", {7'b0, deemph}, 8'h01);
        chk("R11 idle release", {7'b0, sda_pull}, 8'h00);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'h20, a); chk("R2 nack on mismatch", {7'b0, a}, 8'h00);
        send_byte(8'h80, a); chk("R2 ignored byte", {7'b0, a}, 8'h00);
        send_byte(8'hFF, a); chk("R2 ignored data", {7'b0, a}, 8'h00);
        bus_stop();
        check_all("R2 no store");
    endtask

    task automatic t_write_burst();
        logic a;
        bus_start();
        send_byte(8'h22, a); chk("R1 ack write addr", {7'b0, a}, 8'h01);
        send_byte(8'h80, a); chk("R3 ack pointer", {7'b0, a}, 8'h01);
        send_byte(8'hA1, a); chk("R3 ack data", {7'b0, a}, 8'h01);
        send_byte(8'h55, a); chk("R3 ack data", {7'b0, a}, 8'h01);
        send_byte(8'hC3, a); chk("R3 ack data", {7'b0, a}, 8'h01);
        bus_stop();
        m[0] = 8'hA1; m[1] = 8'h55; m[2] = 8'hC3;
        check_all("R3/R5/R6 burst write");
        chk("R6 ctrl merge", regs[15:8], 8'h56);
        chk("R7 pin ctrl off", {7'b0, deemph}, 8'h00);
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        send_byte(8'h22, a); send_byte(8'h87, a);
        send_byte(8'h11, a); send_byte(8'h22, a);
        bus_stop();
        m[7] = 8'h11; m[0] = 8'h22;
        chk("R5 wrap reg7", regs[63:56], 8'h11);
        chk("R5 wrap reg0", regs[7:0], 8'h22);
    endtask

    task automatic t_no_auto();
        logic a;
        bus_start();
        send_byte(8'h22, a); send_byte(8'h03, a);
        send_byte(8'h33, a); send_byte(8'h44, a);
        bus_stop();
        m[3] = 8'h44;
        check_all("R5 no increment");
    endtask

    task automatic t_ro_status();
        logic a;
        bus_start();
        send_byte(8'h22, a); send_byte(8'h06, a);
        send_byte(8'hFF, a); chk("R6 ack status write", {7'b0, a}, 8'h01);
        bus_stop();
        chk("R6 status unchanged", regs[55:48], 8'h5A);
        stat = 8'hC4; hq();
        chk("R6 status follows input", regs[55:48], 8'hC4);
    endtask

    task automatic t_read_restart();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h22, a); send_byte(8'h80, a);
        bus_start();
        send_byte(8'h23, a); chk("R9 ack after restart", {7'b0, a}, 8'h01);
        recv_byte(1'b1, b); chk("R4/R9 read reg0", b, view(0));
        recv_byte(1'b1, b); chk("R4/R6 read reg1", b, view(1));
        recv_byte(1'b0, b); chk("R4 read reg2", b, view(2));
        repeat (4 * Q) begin
            @(negedge clk);
            if (sda_pull) begin chk("R8 released after nack", 8'h01, 8'h00); break; end
        end
        checks++;
        bus_stop();
    endtask

    task automatic t_read_fixed();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h22, a); send_byte(8'h06, a);
        bus_start();
        send_byte(8'h23, a);
        recv_byte(1'b1, b); chk("R4/R6 read status", b, 8'hC4);
        recv_byte(1'b0, b); chk("R5 read stays", b, 8'hC4);
        bus_stop();
    endtask

    task automatic t_strap();
        logic a;
        strap = 0; hq();
        bus_start();
        send_byte(8'h22, a); chk("R1 strap mismatch", {7'b0, a}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'h20, a); chk("R1 strap match", {7'b0, a}, 8'h01);
        send_byte(8'h05, a); send_byte(8'h77, a);
        bus_stop();
        m[5] = 8'h77;
        chk("R1 strap write", regs[47:40], 8'h77);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            checks++;
            if (r11_bad != 0) begin
                errors++;
                $display("FAIL R11 sda changed with scl high actual=%0d expected=0", r11_bad);
            end
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        rst_n = 0; scl_m = 1; sda_m = 1; strap = 1;
        clk_fault = 0; cal_busy = 1; stat = 8'h5A;
        repeat (5) @(negedge clk);
        rst_n = 1;
        hq();
        t_reset();
        t_bad_addr();
        t_write_burst();
        t_wrap();
        t_no_auto();
        t_ro_status();
        t_read_restart();
        t_read_fixed();
        t_strap();
        finish_run();
    end
endmodule